// File: doc/BRIEF.md
# PWM Brightness Scaler with Deferred Update

This block turns a global brightness control into a scaled current code for a sequential LED driver. Only one colour channel is active at a time. The brightness comes from one of three places: a full-scale factor, an 8-bit fader value, or the duty cycle of an external PWM pin measured at the system clock. The block multiplies the 10-bit current setting of the granted channel by that factor and divides by 255, so every channel keeps its ratio to the others.

The PWM duty is measured between successive rising edges. A new brightness is never adopted in the middle of a colour. It is latched only on an enable strobe. A PWM duty that changed fewer than `TIMEOUT` cycles before that strobe is not yet used, so it lands one colour later. A pin with no edge for `TIMEOUT` cycles reads as 0 % duty when low and 100 % duty when high.

All inputs and outputs are plain control and data pins; there is no stream interface and no back-pressure.

Top module: `bright_scaler`

## Requirements
- R1: With mode 2'b00 (bit1 fader-enable, bit0 PWM-enable), the factor latched at an enable strobe is 255, and the output equals the selected current setting.
- R2: With mode 2'b10, the output is floor(setting × fader / 255), using the fader value present at the enable strobe.
- R3: With mode 2'b01 or 2'b11, the output is floor(setting × duty / 255). Here duty = floor(high_cycles × 255 / period_cycles), measured over one full period between rising edges of the PWM pin.
- R4: The brightness factor changes only on a clock edge where some bit of `en_rise` is high. Changing the fader or the PWM input in the middle of a colour leaves the output unchanged.
- R5: A measured duty that changed fewer than `TIMEOUT` cycles before an enable strobe is not used at that strobe; the previous settled duty is used. The new duty is used at the first strobe after it has been stable for longer than `TIMEOUT` cycles.
- R6: If the PWM pin shows no edge for `TIMEOUT` cycles, the duty becomes 0 when the pin is low and 255 when it is high. That value then settles under R5.
- R7: The bank select picks the settings: 2'b00 bank 0, 2'b01 bank 1, 2'b10 and 2'b11 bank 2. In `iset_all`, bank b and channel c occupy bits [(3b+c)×10 +: 10].
- R8: `grant` bit c selects channel c; if several bits are set, the lowest index wins. All channels use the same factor. With no grant the output is 0. The output is registered, so it follows grant, bank and settings one cycle later.
- R9: After reset, `cur_code` is 0. The latched factor is also 0 until the first enable strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | External PWM brightness pin (asynchronous) |
| fader_val | input | 8 | Fader brightness, full scale 255 |
| bright_mode | input | 2 | Bit1 fader-enable, bit0 PWM-enable |
| bank_sel | input | 2 | Current-setting bank select |
| iset_all | input | 90 | Nine 10-bit current settings, bank-major |
| grant | input | 3 | One-hot grant of the active channel |
| en_rise | input | 3 | One-cycle strobes on each channel's enable rising edge |
| cur_code | output | 10 | Scaled current code for the driver |

## Verification
On every cycle, the assertions check four things: the factor holds steady between enable strobes, the unscaled and fader modes latch the expected factor at a strobe, an ungranted output is zero, and the output never exceeds the selected setting. The duty arithmetic can only be shown by the bench's scenarios, which sweep periods and high times of the PWM pin. The same holds for the rule that defers an update by one colour when the duty changed too recently, for the idle-pin readings of 0 % and 100 %, and for bank and channel selection across all nine settings.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int CODE_W   = 10;
  localparam int FACT_W   = 8;
  localparam int NUM_CH   = 3;
  localparam int NUM_BANK = 3;
  localparam int FULL     = 255;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [FACT_W-1:0] fact_t;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_PWM   = 2'b01,
    MODE_FADER = 2'b10,
    MODE_PWM_B = 2'b11
  } bright_mode_e;

  function automatic code_t scale_code(code_t s, fact_t f);
    logic [CODE_W+FACT_W-1:0] prod;
    prod = (CODE_W+FACT_W)'(s) * (CODE_W+FACT_W)'(f);
    return code_t'(prod / (CODE_W+FACT_W)'(FULL));
  endfunction
endpackage

// File: rtl/bsc_divider.sv
module bsc_divider #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  q_q;
  logic [DEN_W:0]    rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] left_q;
  logic              busy_q;
  logic [DEN_W:0]    shifted;
  logic [DEN_W:0]    diff;

  always_comb begin
    shifted = {rem_q[DEN_W-1:0], q_q[NUM_W-1]};
    diff    = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_q    <= num;
        rem_q  <= '0;
        den_q  <= den;
        left_q <= STEP_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (shifted >= {1'b0, den_q}) begin
          rem_q <= diff;
          q_q   <= {q_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= shifted;
          q_q   <= {q_q[NUM_W-2:0], 1'b0};
        end
        left_q <= left_q - STEP_W'(1);
        if (left_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quot = q_q;
endmodule

// File: rtl/bsc_duty_meter.sv
module bsc_duty_meter
  import bsc_pkg::*;
#(
  parameter int TIMEOUT = 300
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwm_in,
  output logic  duty_wr,
  output fact_t duty_val
);
  localparam int CNT_W = $clog2(TIMEOUT + 1) + 1;
  localparam int NUM_W = CNT_W + FACT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync_q;
  logic             lvl, lvl_d, rise, any_edge, idle_evt;
  logic [CNT_W-1:0] per_q, hi_q, age_q;
  logic             armed_q;
  logic             div_go, div_done;
  logic [NUM_W-1:0] div_q;

  assign lvl      = sync_q[1];
  assign lvl_d    = sync_q[2];
  assign rise     = lvl & ~lvl_d;
  assign any_edge = lvl ^ lvl_d;
  assign idle_evt = !any_edge && (age_q == CNT_W'(TIMEOUT - 1));
  assign div_go   = rise && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      per_q   <= '0;
      hi_q    <= '0;
      age_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], pwm_in};
      if (any_edge)                     age_q <= '0;
      else if (age_q != CNT_W'(TIMEOUT)) age_q <= age_q + CNT_W'(1);
      if (rise) begin
        per_q   <= CNT_W'(1);
        hi_q    <= CNT_W'(1);
        armed_q <= 1'b1;
      end else begin
        if (per_q != CNT_MAX)         per_q <= per_q + CNT_W'(1);
        if (lvl && hi_q != CNT_MAX)   hi_q  <= hi_q + CNT_W'(1);
        if (idle_evt)                 armed_q <= 1'b0;
      end
    end
  end

  bsc_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_go),
    .num   (NUM_W'(hi_q) * NUM_W'(FULL)),
    .den   (per_q),
    .done  (div_done),
    .quot  (div_q)
  );

  always_comb begin
    duty_wr  = 1'b0;
    duty_val = '0;
    if (idle_evt) begin
      duty_wr  = 1'b1;
      duty_val = lvl ? fact_t'(FULL) : '0;
    end else if (div_done) begin
      duty_wr  = 1'b1;
      duty_val = (div_q > NUM_W'(FULL)) ? fact_t'(FULL) : div_q[FACT_W-1:0];
    end
  end
endmodule

// File: rtl/bsc_bright_latch.sv
module bsc_bright_latch
  import bsc_pkg::*;
#(
  parameter int TIMEOUT = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       duty_wr,
  input  fact_t      duty_val,
  input  logic [1:0] mode,
  input  fact_t      fader,
  input  logic       en_any,
  output fact_t      factor
);
  localparam int STAB_W = $clog2(TIMEOUT + 1);

  fact_t             duty_q, settled_q, factor_q;
  logic [STAB_W-1:0] stab_q;
  logic              changed, calm;

  assign changed = duty_wr && (duty_val != duty_q);
  assign calm    = (stab_q == STAB_W'(TIMEOUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q    <= '0;
      settled_q <= '0;
      stab_q    <= STAB_W'(TIMEOUT);
      factor_q  <= '0;
    end else begin
      if (duty_wr) duty_q <= duty_val;
      if (changed)    stab_q <= '0;
      else if (!calm) stab_q <= stab_q + STAB_W'(1);
      if (calm) settled_q <= duty_q;
      if (en_any) begin
        unique case (bright_mode_e'(mode))
          MODE_NONE:  factor_q <= fact_t'(FULL);
          MODE_FADER: factor_q <= fader;
          default:    factor_q <= settled_q;
        endcase
      end
    end
  end

  assign factor = factor_q;
endmodule

// File: rtl/bright_scaler.sv
module bright_scaler
  import bsc_pkg::*;
#(
  parameter int TIMEOUT = 300
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pwm_in,
  input  logic [FACT_W-1:0]                 fader_val,
  input  logic [1:0]                        bright_mode,
  input  logic [1:0]                        bank_sel,
  input  logic [NUM_BANK*NUM_CH*CODE_W-1:0] iset_all,
  input  logic [NUM_CH-1:0]                 grant,
  input  logic [NUM_CH-1:0]                 en_rise,
  output logic [CODE_W-1:0]                 cur_code
);
  localparam logic [1:0] LAST_BANK = 2'(NUM_BANK - 1);

  code_t      set_arr [NUM_BANK][NUM_CH];
  code_t      sel_set, cur_q;
  logic [1:0] bank_idx;
  logic       any_grant, duty_wr;
  fact_t      duty_val, factor_w;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign set_arr[b][c] = iset_all[(b*NUM_CH+c)*CODE_W +: CODE_W];
    end
  end

  assign bank_idx = (bank_sel > LAST_BANK) ? LAST_BANK : bank_sel;

  always_comb begin
    sel_set   = '0;
    any_grant = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (grant[c]) begin
        sel_set   = set_arr[bank_idx][c];
        any_grant = 1'b1;
      end
    end
  end

  bsc_duty_meter #(.TIMEOUT(TIMEOUT)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_in   (pwm_in),
    .duty_wr  (duty_wr),
    .duty_val (duty_val)
  );

  bsc_bright_latch #(.TIMEOUT(TIMEOUT)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .duty_wr  (duty_wr),
    .duty_val (duty_val),
    .mode     (bright_mode),
    .fader    (fader_val),
    .en_any   (|en_rise),
    .factor   (factor_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_q <= '0;
    else if (any_grant) cur_q <= scale_code(sel_set, factor_w);
    else                cur_q <= '0;
  end

  assign cur_code = cur_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
  import bsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] grant,
  input logic [NUM_CH-1:0] en_rise,
  input logic [1:0]        bright_mode,
  input logic [FACT_W-1:0] fader_val,
  input logic [FACT_W-1:0] factor,
  input logic [CODE_W-1:0] sel_set,
  input logic [CODE_W-1:0] cur_code
);
  AST_FACTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise == '0) |=> $stable(factor)); // R4

  AST_NOSCALE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ((|en_rise) && bright_mode == 2'b00) |=> (factor == 8'hFF)); // R1

  AST_FADER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((|en_rise) && bright_mode == 2'b10) |=> (factor == $past(fader_val))); // R2

  AST_NO_GRANT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> (cur_code == '0)); // R8

  AST_NOT_ABOVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (cur_code <= $past(sel_set))); // R8
endmodule

bind bright_scaler bsc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant       (grant),
  .en_rise     (en_rise),
  .bright_mode (bright_mode),
  .fader_val   (fader_val),
  .factor      (factor_w),
  .sel_set     (sel_set),
  .cur_code    (cur_code)
);

// File: tb/test_bright_scaler.sv
module test_bright_scaler;
  import bsc_pkg::*;
  localparam int TMO   = 200;
  localparam int SET_W = NUM_BANK*NUM_CH*CODE_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwm_in = 1'b0;
  logic [7:0]       fader_val = '0;
  logic [1:0]       bright_mode = '0;
  logic [1:0]       bank_sel = '0;
  logic [SET_W-1:0] iset_all = '0;
  logic [2:0]       grant = '0;
  logic [2:0]       en_rise = '0;
  logic [9:0]       cur_code;

  int n_chk = 0;
  int n_err = 0;
  int pwm_per = 40;
  int pwm_hi = 20;
  int pwm_kind = 1;   // 0 toggling, 1 held low, 2 held high

  always #4 clk = ~clk;

  bright_scaler #(.TIMEOUT(TMO)) i_bright_scaler (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fader_val(fader_val),
    .bright_mode(bright_mode), .bank_sel(bank_sel), .iset_all(iset_all),
    .grant(grant), .en_rise(en_rise), .cur_code(cur_code)
  );

  initial begin
    forever begin
      if (pwm_kind == 0) begin
        pwm_in = 1'b1;
        repeat (pwm_hi) @(negedge clk);
        pwm_in = 1'b0;
        repeat (pwm_per - pwm_hi) @(negedge clk);
      end else begin
        pwm_in = (pwm_kind == 2);
        @(negedge clk);
      end
    end
  end

  function automatic int setv(int b, int c);
    return (b*3 + c)*113 + 37;
  endfunction

  function automatic int expv(int s, int f);
    return (s*f)/255;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic colour(int ch);
    @(negedge clk);
    grant   = 3'(1 << ch);
    en_rise = 3'(1 << ch);
    @(negedge clk);
    en_rise = '0;
    wait_cyc(2);
  endtask

  task automatic set_pwm(int per, int hi);
    pwm_per  = per;
    pwm_hi   = hi;
    pwm_kind = 0;
  endtask

  initial begin
    #(8*200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int b = 0; b < 3; b++)
      for (int c = 0; c < 3; c++)
        iset_all[(b*3+c)*10 +: 10] = 10'(setv(b, c));
    wait_cyc(5);
    chk("R9 reset output", int'(cur_code), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    grant = 3'b001;
    wait_cyc(2);
    chk("R9 factor zero before first strobe", int'(cur_code), 0);

    // R1 and R7: no scaling, every bank select code and channel
    bright_mode = 2'b00;
    for (int bs = 0; bs < 4; bs++) begin
      bank_sel = 2'(bs);
      for (int c = 0; c < 3; c++) begin
        colour(c);
        chk(bs == 3 ? "R7 code 11 picks bank2" : "R1 unscaled",
            int'(cur_code), setv(bs > 2 ? 2 : bs, c));
      end
    end
    bank_sel = 2'b00;
    wait_cyc(2);
    chk("R7 live bank change", int'(cur_code), setv(0, 2));
    grant = 3'b110;
    wait_cyc(2);
    chk("R8 lowest grant wins", int'(cur_code), setv(0, 1));
    grant = '0;
    wait_cyc(2);
    chk("R8 no grant zero", int'(cur_code), 0);

    // R2 fader sweep
    bright_mode = 2'b10;
    bank_sel = 2'b01;
    foreach (fader_val[i]) ; // keep loop-free idiom simple
    for (int k = 0; k < 7; k++) begin
      int f;
      f = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 64 : (k == 3) ? 128 :
          (k == 4) ? 200 : (k == 5) ? 254 : 255;
      fader_val = 8'(f);
      for (int c = 0; c < 3; c++) begin
        colour(c);
        chk("R2 fader scale", int'(cur_code), expv(setv(1, c), f));
      end
    end
    iset_all[3*10 +: 10] = 10'd1023;
    fader_val = 8'd254;
    colour(0);
    chk("R2 full-range setting", int'(cur_code), expv(1023, 254));
    iset_all[3*10 +: 10] = 10'(setv(1, 0));

    // R4 mid-colour change ignored
    fader_val = 8'd100;
    colour(1);
    chk("R4 before change", int'(cur_code), expv(setv(1, 1), 100));
    fader_val = 8'd30;
    wait_cyc(6);
    chk("R4 fader change mid-colour", int'(cur_code), expv(setv(1, 1), 100));
    colour(1);
    chk("R4 taken at next strobe", int'(cur_code), expv(setv(1, 1), 30));

    // R3 and R8 PWM duty sweep
    bank_sel = 2'b10;
    for (int k = 0; k < 6; k++) begin
      int per;
      int hi;
      int d;
      per = (k == 0) ? 40 : (k == 1) ? 40 : (k == 2) ? 50 : (k == 3) ? 64 : (k == 4) ? 25 : 33;
      hi  = (k == 0) ? 10 : (k == 1) ? 30 : (k == 2) ? 1  : (k == 3) ? 63 : (k == 4) ? 12 : 17;
      bright_mode = (k == 5) ? 2'b11 : 2'b01;
      set_pwm(per, hi);
      d = (hi*255)/per;
      wait_cyc(3*per + 40 + TMO + 10);
      for (int c = 0; c < 3; c++) begin
        colour(c);
        chk(c == 0 ? "R3 pwm duty" : "R8 same factor per channel",
            int'(cur_code), expv(setv(2, c), d));
      end
      pwm_in = pwm_in;
      fader_val = 8'd7;
      colour(0);
      chk("R3 fader ignored in pwm mode", int'(cur_code), expv(setv(2, 0), d));
    end

    // R5 deferred adoption
    bright_mode = 2'b01;
    set_pwm(40, 10);
    wait_cyc(3*40 + 40 + TMO + 10);
    colour(2);
    chk("R5 settled start", int'(cur_code), expv(setv(2, 2), 63));
    set_pwm(40, 30);
    wait_cyc(150);
    colour(2);
    chk("R5 recent change kept old", int'(cur_code), expv(setv(2, 2), 63));
    wait_cyc(TMO + 20);
    colour(2);
    chk("R5 applied one colour later", int'(cur_code), expv(setv(2, 2), 191));

    // R6 idle pin
    pwm_kind = 1;
    wait_cyc(2*TMO + 100);
    colour(1);
    chk("R6 held low reads zero", int'(cur_code), 0);
    pwm_kind = 2;
    wait_cyc(2*TMO + 100);
    colour(1);
    chk("R6 held high reads full", int'(cur_code), setv(2, 1));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule